// File: doc/BRIEF.md
# Level-Crossing Gate Controller

This block coordinates one train and one crossing gate with tick-counted clocks. A train's arrival makes the block command the gate shut. When the gate reports it has finished closing, the block lets the train through. When the train reports it has cleared the crossing, the block commands the gate open again. A `tick` input marks one time unit. Two saturating clocks count those units. The train clock starts at zero when an arrival is accepted. The gate clock starts at zero when the gate takes the close command.

Every handshake must happen inside a clock window, and the block never waits for a late event:

- A train that is not let through before its clock reaches the limit goes into a braking state.
- A gate that has not finished closing once its clock passes the upper bound goes into a repair state.
- A finished-closing report that comes too late for the sequencer locks the sequencer, so the train is never let through.

All fault states are sticky. Only the synchronous reset clears them.

States:

- **Sequencer:** SQ_IDLE, SQ_CLOSE, SQ_WAIT_ACK, SQ_PROCEED, SQ_WAIT_CLEAR, SQ_OPEN, SQ_LOCKED.
  - Transitions: idle→close on an accepted arrival; close→wait_ack always; wait_ack→proceed on an in-window acknowledgement; wait_ack→locked when the gate clock passes 3; proceed→wait_clear always; wait_clear→open on departure; open→idle always.
- **Gate:** GT_OPEN, GT_CLOSING, GT_CLOSED, GT_REPAIR.
  - Transitions: open→closing on the close pulse; closing→closed on an acknowledgement with the gate clock in 2..4; closing→repair when the gate clock passes 4; closed→open on the open pulse.
- **Train:** TR_IDLE, TR_NEAR, TR_GO, TR_BRAKE.
  - Transitions: idle→near on an accepted arrival; near→go on the proceed pulse while the train clock is below 5; near→brake when the train clock reaches 5; go→idle on departure.

Top module: `lxing_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, all five outputs are 0. The gate is open and the train is idle, so an arrival that follows is accepted.
- R2: An arrival (`train_near`=1) seen in SQ_IDLE raises `close_o` for exactly one cycle, in the cycle after the arrival. That arrival zeroes the train clock, and the close pulse zeroes the gate clock.
- R3: A `gate_done` seen while waiting, with the gate clock in 2..3, raises `proceed_o` for exactly one cycle, in the next cycle. A `gate_done` seen while the gate clock is below 2 is ignored.
- R4: A `train_gone` seen after proceed raises `open_o` for exactly one cycle, in the next cycle. The block then returns to idle and accepts a new arrival.
- R5: An arrival seen while a crossing cycle is in progress produces no `close_o`.
- R6: If the train clock reaches 5 before proceed, `brake_o` rises in the following cycle.
- R7: If the gate clock passes 4 while the gate is still closing, `repair_o` rises in the following cycle.
- R8: A `gate_done` seen at gate clock 4 closes the gate, so `repair_o` stays 0. It misses the sequencer's 3-unit bound, so no `proceed_o` is ever raised and the train brakes.
- R9: Clocks advance by one only in a cycle with `tick`=1, and they hold at 15 rather than wrap.
- R10: `brake_o`, `repair_o` and the sequencer lockout stay set under any input until `rst`. While locked, no `close_o` or `open_o` is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One time unit elapses in this cycle |
| train_near | input | 1 | Train arrival request |
| train_gone | input | 1 | Train has cleared the crossing |
| gate_done | input | 1 | Gate reports it has finished closing |
| proceed_o | output | 1 | One-cycle permission for the train |
| close_o | output | 1 | One-cycle close command to the gate |
| open_o | output | 1 | One-cycle open command to the gate |
| brake_o | output | 1 | Train is braking (sticky) |
| repair_o | output | 1 | Gate needs repair (sticky) |

## Verification
Command pulses (`close_o`, `proceed_o`, `open_o`) are due one cycle after the input that triggers them, because each comes from a registered state. The bench drives every input at a falling edge and reads the outputs just after the next rising edge, so each vector row compares the result of exactly one edge. A fault flag is due two edges after the tick that carries a clock over its bound: one edge for the clock to move, one for the state machine to react. The directed tests read the flag still low after the crossing tick and high one cycle later. This pins the bounds of 5, 3 and 4 to the cycle.

// File: rtl/lx_pkg.sv
package lx_pkg;

    localparam int LX_CNT_W       = 4;
    localparam int LX_TRAIN_LIMIT = 5;
    localparam int LX_GATE_MIN    = 2;
    localparam int LX_GATE_MAX    = 4;
    localparam int LX_SEQ_MAX     = 3;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CLOSE,
        SQ_WAIT_ACK,
        SQ_PROCEED,
        SQ_WAIT_CLEAR,
        SQ_OPEN,
        SQ_LOCKED
    } seq_state_e;

    typedef enum logic [1:0] {
        GT_OPEN,
        GT_CLOSING,
        GT_CLOSED,
        GT_REPAIR
    } gate_state_e;

    typedef enum logic [1:0] {
        TR_IDLE,
        TR_NEAR,
        TR_GO,
        TR_BRAKE
    } train_state_e;

endpackage

// File: rtl/lx_tick_timer.sv
module lx_tick_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick && (cnt != TOP)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lx_sequencer.sv
module lx_sequencer
    import lx_pkg::*;
#(
    parameter int CNT_W    = LX_CNT_W,
    parameter int GATE_MIN = LX_GATE_MIN,
    parameter int SEQ_MAX  = LX_SEQ_MAX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             train_near,
    input  logic             train_gone,
    input  logic             gate_done,
    input  logic [CNT_W-1:0] g_count,
    output logic             accept_o,
    output logic             close_o,
    output logic             proceed_o,
    output logic             open_o
);
    localparam logic [CNT_W-1:0] LO = CNT_W'(GATE_MIN);
    localparam logic [CNT_W-1:0] HI = CNT_W'(SEQ_MAX);

    seq_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:       if (train_near) state_d = SQ_CLOSE;
            SQ_CLOSE:      state_d = SQ_WAIT_ACK;
            SQ_WAIT_ACK: begin
                if (gate_done && (g_count >= LO) && (g_count <= HI))
                    state_d = SQ_PROCEED;
                else if (g_count > HI)
                    state_d = SQ_LOCKED;
            end
            SQ_PROCEED:    state_d = SQ_WAIT_CLEAR;
            SQ_WAIT_CLEAR: if (train_gone) state_d = SQ_OPEN;
            SQ_OPEN:       state_d = SQ_IDLE;
            SQ_LOCKED:     state_d = SQ_LOCKED;
            default:       state_d = SQ_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        accept_o  = (state_q == SQ_IDLE) && train_near;
        close_o   = (state_q == SQ_CLOSE);
        proceed_o = (state_q == SQ_PROCEED);
        open_o    = (state_q == SQ_OPEN);
    end
endmodule

// File: rtl/lx_gate_fsm.sv
module lx_gate_fsm
    import lx_pkg::*;
#(
    parameter int CNT_W    = LX_CNT_W,
    parameter int GATE_MIN = LX_GATE_MIN,
    parameter int GATE_MAX = LX_GATE_MAX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             close_i,
    input  logic             open_i,
    input  logic             gate_done,
    input  logic [CNT_W-1:0] g_count,
    output logic             repair_o
);
    localparam logic [CNT_W-1:0] LO = CNT_W'(GATE_MIN);
    localparam logic [CNT_W-1:0] HI = CNT_W'(GATE_MAX);

    gate_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= GT_OPEN;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GT_OPEN:    if (close_i) state_d = GT_CLOSING;
            GT_CLOSING: begin
                if (gate_done && (g_count >= LO) && (g_count <= HI))
                    state_d = GT_CLOSED;
                else if (g_count > HI)
                    state_d = GT_REPAIR;
            end
            GT_CLOSED:  if (open_i) state_d = GT_OPEN;
            GT_REPAIR:  state_d = GT_REPAIR;
            default:    state_d = GT_REPAIR;
        endcase
    end

    // outputs
    always_comb begin
        repair_o = (state_q == GT_REPAIR);
    end
endmodule

// File: rtl/lx_train_fsm.sv
module lx_train_fsm
    import lx_pkg::*;
#(
    parameter int CNT_W       = LX_CNT_W,
    parameter int TRAIN_LIMIT = LX_TRAIN_LIMIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_i,
    input  logic             proceed_i,
    input  logic             train_gone,
    input  logic [CNT_W-1:0] t_count,
    output logic             brake_o
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(TRAIN_LIMIT);

    train_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= TR_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TR_IDLE:  if (accept_i) state_d = TR_NEAR;
            TR_NEAR: begin
                if (proceed_i && (t_count < LIM))
                    state_d = TR_GO;
                else if (t_count >= LIM)
                    state_d = TR_BRAKE;
            end
            TR_GO:    if (train_gone) state_d = TR_IDLE;
            TR_BRAKE: state_d = TR_BRAKE;
            default:  state_d = TR_BRAKE;
        endcase
    end

    // outputs
    always_comb begin
        brake_o = (state_q == TR_BRAKE);
    end
endmodule

// File: rtl/lxing_ctrl.sv
module lxing_ctrl
    import lx_pkg::*;
#(
    parameter int CNT_W       = LX_CNT_W,
    parameter int TRAIN_LIMIT = LX_TRAIN_LIMIT,
    parameter int GATE_MIN    = LX_GATE_MIN,
    parameter int GATE_MAX    = LX_GATE_MAX,
    parameter int SEQ_MAX     = LX_SEQ_MAX
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic train_near,
    input  logic train_gone,
    input  logic gate_done,
    output logic proceed_o,
    output logic close_o,
    output logic open_o,
    output logic brake_o,
    output logic repair_o
);
    localparam int N_CLK = 2;   // index 0: train clock, 1: gate clock

    logic             t_clear, g_clear, accept;
    logic [CNT_W-1:0] t_count, g_count;
    logic [N_CLK-1:0] clr_vec;
    logic [CNT_W-1:0] cnt_arr [N_CLK];

    assign t_clear = accept;
    assign g_clear = close_o;
    assign clr_vec = {g_clear, t_clear};

    for (genvar i = 0; i < N_CLK; i++) begin : g_timer
        lx_tick_timer #(.W(CNT_W)) u_tmr (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr_vec[i]),
            .tick (tick),
            .cnt  (cnt_arr[i])
        );
    end

    assign t_count = cnt_arr[0];
    assign g_count = cnt_arr[1];

    lx_sequencer #(
        .CNT_W(CNT_W), .GATE_MIN(GATE_MIN), .SEQ_MAX(SEQ_MAX)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .train_near (train_near),
        .train_gone (train_gone),
        .gate_done  (gate_done),
        .g_count    (g_count),
        .accept_o   (accept),
        .close_o    (close_o),
        .proceed_o  (proceed_o),
        .open_o     (open_o)
    );

    lx_gate_fsm #(
        .CNT_W(CNT_W), .GATE_MIN(GATE_MIN), .GATE_MAX(GATE_MAX)
    ) u_gate (
        .clk       (clk),
        .rst       (rst),
        .close_i   (close_o),
        .open_i    (open_o),
        .gate_done (gate_done),
        .g_count   (g_count),
        .repair_o  (repair_o)
    );

    lx_train_fsm #(
        .CNT_W(CNT_W), .TRAIN_LIMIT(TRAIN_LIMIT)
    ) u_train (
        .clk        (clk),
        .rst        (rst),
        .accept_i   (accept),
        .proceed_i  (proceed_o),
        .train_gone (train_gone),
        .t_count    (t_count),
        .brake_o    (brake_o)
    );
endmodule

// File: rtl/lxing_ctrl_chk.sv
module lxing_ctrl_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             train_near,
    input logic             gate_done,
    input logic             proceed_o,
    input logic             close_o,
    input logic             open_o,
    input logic             brake_o,
    input logic             repair_o,
    input logic             t_clear,
    input logic             g_clear,
    input logic [CNT_W-1:0] t_count,
    input logic [CNT_W-1:0] g_count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // R2
    cmd_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({proceed_o, close_o, open_o}));

    // R2
    close_single_chk: assert property (@(posedge clk) disable iff (rst)
        close_o |=> !close_o);

    // R2
    close_cause_chk: assert property (@(posedge clk) disable iff (rst)
        close_o |-> $past(train_near));

    // R3
    proceed_single_chk: assert property (@(posedge clk) disable iff (rst)
        proceed_o |=> !proceed_o);

    // R3
    proceed_cause_chk: assert property (@(posedge clk) disable iff (rst)
        proceed_o |-> $past(gate_done));

    // R4
    open_single_chk: assert property (@(posedge clk) disable iff (rst)
        open_o |=> !open_o);

    // R6
    brake_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        brake_o |=> brake_o);

    // R7
    repair_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        repair_o |=> repair_o);

    // R9
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !g_clear) |=> $stable(g_count));

    // R9
    train_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !t_clear) |=> $stable(t_count));

    // R9
    gate_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (g_count == TOP && !g_clear) |=> (g_count == TOP));

    // R9
    train_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (t_count == TOP && !t_clear) |=> (t_count == TOP));
endmodule

bind lxing_ctrl lxing_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .train_near (train_near),
    .gate_done  (gate_done),
    .proceed_o  (proceed_o),
    .close_o    (close_o),
    .open_o     (open_o),
    .brake_o    (brake_o),
    .repair_o   (repair_o),
    .t_clear    (t_clear),
    .g_clear    (g_clear),
    .t_count    (t_count),
    .g_count    (g_count)
);

// File: tb/lxing_ctrl_tb_top.sv
`timescale 1ns/1ps
module lxing_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, train_near = 1'b0, train_gone = 1'b0, gate_done = 1'b0;
    logic proceed_o, close_o, open_o, brake_o, repair_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int pcount = 0;

    always #2.5 clk = ~clk;

    lxing_ctrl dut_i (
        .clk(clk), .rst(rst), .tick(tick), .train_near(train_near),
        .train_gone(train_gone), .gate_done(gate_done),
        .proceed_o(proceed_o), .close_o(close_o), .open_o(open_o),
        .brake_o(brake_o), .repair_o(repair_o)
    );

    // row: [8]near [7]gone [6]done [5]tick | [4]proceed [3]close [2]open [1]brake [0]repair
    localparam int NV = 28;
    localparam logic [8:0] VEC [NV] = '{
        9'b1000_01000, // R2 arrival -> close
        9'b0000_00000,
        9'b0001_00000,
        9'b0001_00000, // gate clock 2
        9'b0010_10000, // R3 ack in window -> proceed
        9'b0000_00000,
        9'b0001_00000,
        9'b1000_00000, // R5 arrival mid-cycle ignored
        9'b0100_00100, // R4 departure -> open
        9'b0000_00000,
        9'b1000_01000, // second crossing
        9'b0000_00000,
        9'b0001_00000,
        9'b0001_00000,
        9'b0001_00000, // gate clock 3
        9'b0010_10000, // R3 ack at upper edge
        9'b0000_00000,
        9'b0100_00100,
        9'b0000_00000,
        9'b1000_01000, // third crossing
        9'b0000_00000,
        9'b0001_00000, // gate clock 1
        9'b0010_00000, // R3 early ack ignored
        9'b0001_00000,
        9'b0010_10000,
        9'b0000_00000,
        9'b0100_00100,
        9'b0000_00000
    };

    always @(negedge clk) if (proceed_o) pcount++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: run hung, act=%0d exp<=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%b exp=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic a, input logic l, input logic d, input logic t);
        @(negedge clk);
        train_near = a; train_gone = l; gate_done = d; tick = t;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; train_near = 0; train_gone = 0; gate_done = 0; tick = 0;
        @(posedge clk); @(posedge clk);
        #1;
        chk("R1 proceed in reset", proceed_o, 1'b0);
        chk("R10 brake in reset", brake_o, 1'b0);
        chk("R10 repair in reset", repair_o, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        cyc(0, 0, 0, 0);
        chk("R1 proceed", proceed_o, 1'b0);
        chk("R1 close", close_o, 1'b0);
        chk("R1 open", open_o, 1'b0);
        chk("R1 brake", brake_o, 1'b0);
        chk("R1 repair", repair_o, 1'b0);

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
            chk($sformatf("R3 proceed row %0d", i), proceed_o, VEC[i][4]);
            chk($sformatf("R2 close row %0d", i),   close_o,   VEC[i][3]);
            chk($sformatf("R4 open row %0d", i),    open_o,    VEC[i][2]);
            chk($sformatf("R6 brake row %0d", i),   brake_o,   VEC[i][1]);
            chk($sformatf("R7 repair row %0d", i),  repair_o,  VEC[i][0]);
        end

        // no acknowledgement: both timeouts
        do_reset();
        pcount = 0;
        cyc(1, 0, 0, 0);
        chk("R2 close after arrival", close_o, 1'b1);
        cyc(1, 0, 0, 0);
        chk("R5 repeated arrival gives no close", close_o, 1'b0);
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1); // clocks reach 5
        chk("R6 brake not before bound", brake_o, 1'b0);
        chk("R7 repair not before bound", repair_o, 1'b0);
        cyc(0, 0, 0, 0);
        chk("R6 brake at bound", brake_o, 1'b1);
        chk("R7 repair past bound", repair_o, 1'b1);
        for (int k = 0; k < 20; k++) cyc(0, 0, 0, 1);
        chk("R9 brake after saturation", brake_o, 1'b1);
        chk("R9 repair after saturation", repair_o, 1'b1);
        cyc(0, 1, 0, 0);
        chk("R10 locked: no open", open_o, 1'b0);
        cyc(0, 0, 1, 0);
        cyc(1, 0, 0, 0);
        chk("R10 locked: no close", close_o, 1'b0);
        chk("R10 brake held", brake_o, 1'b1);
        chk("R10 repair held", repair_o, 1'b1);
        chk("R6 no proceed seen", (pcount == 0), 1'b1);

        // late acknowledgement at gate clock 4
        do_reset();
        pcount = 0;
        cyc(1, 0, 0, 0);
        chk("R1 arrival accepted after reset", close_o, 1'b1);
        cyc(0, 0, 0, 0);
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        chk("R8 no proceed on late ack", proceed_o, 1'b0);
        cyc(0, 0, 0, 1); // train clock 5
        chk("R8 brake not yet", brake_o, 1'b0);
        cyc(0, 0, 0, 0);
        chk("R8 brake after missed bound", brake_o, 1'b1);
        chk("R8 gate closed, no repair", repair_o, 1'b0);
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 0);
        chk("R8 repair stays low", repair_o, 1'b0);
        chk("R8 proceed never seen", (pcount == 0), 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule